// File: doc/BRIEF.md
# CPU exception entry and return controller

This block handles the control side of exception entry and exception return in a 32-bit in-order CPU core. The core presents an exception request together with a cause number, the PC of the faulting instruction, a flag that marks a delay-slot instruction, and the current status register. The block then does four things:

- It saves the correct resume PC, the status register and, for illegal instructions, the faulting address.
- It builds the write value for the new status register.
- It computes the handler vector.
- It issues a one-cycle redirect to the fetch unit.

A debug-trap cause does not vector. It raises a halt pulse that carries the PC instead.

On a return-from-exception strobe, the block does the following:

- It rebuilds the status register from the saved copy and forces its fixed-one bit to one.
- It redirects fetch to the saved PC.
- It pulses a clear for any pending next-delay-slot state.

Every output is registered. The results of a request sampled at one clock edge are visible after that edge.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, `epcr_o`, `esr_o`, `eear_o`, `redir_pc_o`, `sr_wdata_o` and `halt_pc_o` are zero. `redir_valid_o`, `sr_we_o`, `halt_o`, `cause_err_o` and `clr_dslot_o` are low.
- R2: For cause 0xC (system call) and cause 0xD (floating point), `epcr_o` becomes PC+4. If `dslot_i` is high, it becomes PC unchanged.
- R3: For cause 0x2 (bus error), 0x6 (alignment), 0x7 (illegal) and 0xB (range), `epcr_o` becomes PC. If `dslot_i` is high, it becomes PC-4.
- R4: Cause 0x1 (reset) leaves `epcr_o` unchanged. It still saves the status register and vectors.
- R5: On a vectored entry, `esr_o` takes `sr_i`. In the same cycle, `sr_we_o` pulses with `sr_wdata_o` equal to `sr_i` with bit 13 (delay-slot exception) replaced by `dslot_i`.
- R6: On a vectored entry, `redir_valid_o` is high for exactly one cycle, the cycle after the request. During that cycle, `redir_pc_o` = (0xF000_0000 if `sr_i` bit 14 is set, else 0) + (cause << 8).
- R7: Cause 0xE (trap) pulses `halt_o` with `halt_pc_o` equal to PC. It produces no redirect, no status write, and no change to `epcr_o`, `esr_o` or `eear_o`.
- R8: Only cause 0x7 loads `eear_o` with the faulting PC. Other causes leave `eear_o` unchanged.
- R9: On `rfe_i`, `sr_we_o` pulses with `sr_wdata_o` = `esr_o` with bit 15 forced to 1, and `redir_valid_o` pulses with `redir_pc_o` = `epcr_o`.
- R10: `clr_dslot_o` pulses for one cycle after every vectored entry and every return. It does not pulse after a trap or an unknown cause.
- R11: Any other cause pulses `cause_err_o`. It produces no redirect, no halt, and no change to the saved registers.
- R12: If `exc_req_i` and `rfe_i` are high in the same cycle, the exception is taken and the return is ignored.
- R13: With neither `exc_req_i` nor `rfe_i` high, the saved registers hold their values and no output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_req_i | input | 1 | Exception request, one cycle |
| exc_cause_i | input | 5 | Exception cause number |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| dslot_i | input | 1 | Faulting instruction is in a delay slot |
| sr_i | input | 32 | Current status register |
| rfe_i | input | 1 | Return-from-exception strobe |
| redir_valid_o | output | 1 | Fetch redirect pulse |
| redir_pc_o | output | 32 | Redirect target PC |
| sr_we_o | output | 1 | Status register write pulse |
| sr_wdata_o | output | 32 | Status register write value |
| epcr_o | output | 32 | Saved exception PC |
| esr_o | output | 32 | Saved status register |
| eear_o | output | 32 | Saved effective address |
| halt_o | output | 1 | Debug halt pulse |
| halt_pc_o | output | 32 | PC reported with the halt |
| cause_err_o | output | 1 | Unknown cause pulse |
| clr_dslot_o | output | 1 | Clear pending next-delay-slot state |

## Verification
The hardest situations to bring about are those where the outputs must stay unchanged, because only state left by an earlier exception can reveal an unwanted write. For these cases, the bench first takes an exception that leaves known values in the saved registers. It then applies a trap, a reset cause, an unknown cause or an idle stretch, and checks those values again at the ports. The collision of a request with a return is driven in one cycle. The status value sent with it is chosen so that a wrongly taken return would produce a status write and a redirect target that can be told apart from those of the exception.

// File: rtl/exc_pkg.sv
package exc_pkg;
  parameter int unsigned C_RESET   = 1;
  parameter int unsigned C_BUSERR  = 2;
  parameter int unsigned C_ALIGN   = 6;
  parameter int unsigned C_ILLEGAL = 7;
  parameter int unsigned C_RANGE   = 11;
  parameter int unsigned C_SYSCALL = 12;
  parameter int unsigned C_FPU     = 13;
  parameter int unsigned C_TRAP    = 14;

  typedef enum logic [2:0] {
    CLS_NEXT,   // resume after faulting insn
    CLS_CUR,    // re-execute faulting insn
    CLS_RESET,
    CLS_TRAP,
    CLS_BAD
  } exc_class_e;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_pkg::*;
#(
  parameter int unsigned CAUSE_W = 5
) (
  input  logic [CAUSE_W-1:0] cause_i,
  output exc_class_e         cls_o,
  output logic               illegal_o
);
  always_comb begin
    illegal_o = (cause_i == CAUSE_W'(C_ILLEGAL));
    if (cause_i == CAUSE_W'(C_SYSCALL) || cause_i == CAUSE_W'(C_FPU))
      cls_o = CLS_NEXT;
    else if (cause_i == CAUSE_W'(C_BUSERR) || cause_i == CAUSE_W'(C_ALIGN) ||
             cause_i == CAUSE_W'(C_ILLEGAL) || cause_i == CAUSE_W'(C_RANGE))
      cls_o = CLS_CUR;
    else if (cause_i == CAUSE_W'(C_RESET))
      cls_o = CLS_RESET;
    else if (cause_i == CAUSE_W'(C_TRAP))
      cls_o = CLS_TRAP;
    else
      cls_o = CLS_BAD;
  end
endmodule

// File: rtl/exc_pc_calc.sv
module exc_pc_calc
  import exc_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned INSN_SZ = 4
) (
  input  exc_class_e      cls_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            dslot_i,
  output logic [XLEN-1:0] epc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_SZ);

  always_comb begin
    if (cls_i == CLS_NEXT)
      epc_o = dslot_i ? pc_i : pc_i + STEP;
    else
      epc_o = dslot_i ? pc_i - STEP : pc_i;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int unsigned     XLEN      = 32,
  parameter int unsigned     CAUSE_W   = 5,
  parameter int unsigned     VEC_SHIFT = 8,
  parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000
) (
  input  logic               prefix_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    handler_o
);
  logic [XLEN-1:0] offs;

  always_comb begin
    offs      = XLEN'(cause_i) << VEC_SHIFT;
    handler_o = (prefix_i ? HI_BASE : '0) + offs;
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter int unsigned     CAUSE_W   = 5,
  parameter int unsigned     VEC_SHIFT = 8,
  parameter int unsigned     INSN_SZ   = 4,
  parameter int unsigned     FO_BIT    = 15,
  parameter int unsigned     EPH_BIT   = 14,
  parameter int unsigned     DSX_BIT   = 13,
  parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_req_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    exc_pc_i,
  input  logic               dslot_i,
  input  logic [XLEN-1:0]    sr_i,
  input  logic               rfe_i,
  output logic               redir_valid_o,
  output logic [XLEN-1:0]    redir_pc_o,
  output logic               sr_we_o,
  output logic [XLEN-1:0]    sr_wdata_o,
  output logic [XLEN-1:0]    epcr_o,
  output logic [XLEN-1:0]    esr_o,
  output logic [XLEN-1:0]    eear_o,
  output logic               halt_o,
  output logic [XLEN-1:0]    halt_pc_o,
  output logic               cause_err_o,
  output logic               clr_dslot_o
);
  localparam logic [XLEN-1:0] FO_MASK = XLEN'(1) << FO_BIT;

  exc_class_e      cls;
  logic            is_ill;
  logic [XLEN-1:0] epc_new, handler;
  logic            vec_ok, do_rfe, do_trap, do_bad;
  logic [XLEN-1:0] sr_entry;

  exc_decode #(.CAUSE_W(CAUSE_W)) u_dec (
    .cause_i  (exc_cause_i),
    .cls_o    (cls),
    .illegal_o(is_ill)
  );

  exc_pc_calc #(.XLEN(XLEN), .INSN_SZ(INSN_SZ)) u_pc (
    .cls_i  (cls),
    .pc_i   (exc_pc_i),
    .dslot_i(dslot_i),
    .epc_o  (epc_new)
  );

  exc_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_SHIFT(VEC_SHIFT),
               .HI_BASE(HI_BASE)) u_vec (
    .prefix_i (sr_i[EPH_BIT]),
    .cause_i  (exc_cause_i),
    .handler_o(handler)
  );

  always_comb begin
    vec_ok  = exc_req_i && (cls == CLS_NEXT || cls == CLS_CUR || cls == CLS_RESET);
    do_trap = exc_req_i && (cls == CLS_TRAP);
    do_bad  = exc_req_i && (cls == CLS_BAD);
    do_rfe  = rfe_i && !exc_req_i;  // exception wins a collision
    sr_entry          = sr_i;
    sr_entry[DSX_BIT] = dslot_i;
  end

  logic            redir_v_q, sr_we_q, halt_q, err_q, clr_q;
  logic [XLEN-1:0] redir_pc_q, sr_wd_q, epcr_q, esr_q, eear_q, halt_pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_v_q  <= 1'b0;
      redir_pc_q <= '0;
      sr_we_q    <= 1'b0;
      sr_wd_q    <= '0;
      clr_q      <= 1'b0;
    end else begin
      redir_v_q <= vec_ok || do_rfe;
      sr_we_q   <= vec_ok || do_rfe;
      clr_q     <= vec_ok || do_rfe;
      if (vec_ok) begin
        redir_pc_q <= handler;
        sr_wd_q    <= sr_entry;
      end else if (do_rfe) begin
        redir_pc_q <= epcr_q;
        sr_wd_q    <= esr_q | FO_MASK;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epcr_q <= '0;
      esr_q  <= '0;
      eear_q <= '0;
    end else if (vec_ok) begin
      esr_q <= sr_i;
      if (cls != CLS_RESET) epcr_q <= epc_new;
      if (is_ill)           eear_q <= exc_pc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q    <= 1'b0;
      halt_pc_q <= '0;
      err_q     <= 1'b0;
    end else begin
      halt_q <= do_trap;
      err_q  <= do_bad;
      if (do_trap) halt_pc_q <= exc_pc_i;
    end
  end

  assign redir_valid_o = redir_v_q;
  assign redir_pc_o    = redir_pc_q;
  assign sr_we_o       = sr_we_q;
  assign sr_wdata_o    = sr_wd_q;
  assign epcr_o        = epcr_q;
  assign esr_o         = esr_q;
  assign eear_o        = eear_q;
  assign halt_o        = halt_q;
  assign halt_pc_o     = halt_pc_q;
  assign cause_err_o   = err_q;
  assign clr_dslot_o   = clr_q;

  AST_REDIR_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_v_q |-> $past(exc_req_i || rfe_i)); // R6
  AST_EPCR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_req_i |=> $stable(epcr_q)); // R13
  AST_ESR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_req_i |=> $stable(esr_q)); // R13
  AST_TRAP_NO_REDIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> !redir_v_q && !sr_we_q); // R7
  AST_RFE_FO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i && !exc_req_i) |=> sr_wd_q[FO_BIT]); // R9
  AST_BAD_NO_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_bad |=> $stable(epcr_q) && $stable(esr_q) && $stable(eear_q)); // R11
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({redir_v_q, halt_q, err_q}) <= 1); // R10
endmodule

// File: tb/exc_ctrl_bench.sv
module exc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0, dslot = 1'b0, rfe = 1'b0;
  logic [4:0]  cause = '0;
  logic [31:0] pc = '0, sr = '0;
  logic        redir_v, sr_we, halt, cerr, clr_ds;
  logic [31:0] redir_pc, sr_wd, epcr, esr, eear, halt_pc;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  exc_ctrl u_exc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .exc_cause_i(cause),
    .exc_pc_i(pc), .dslot_i(dslot), .sr_i(sr), .rfe_i(rfe),
    .redir_valid_o(redir_v), .redir_pc_o(redir_pc), .sr_we_o(sr_we),
    .sr_wdata_o(sr_wd), .epcr_o(epcr), .esr_o(esr), .eear_o(eear),
    .halt_o(halt), .halt_pc_o(halt_pc), .cause_err_o(cerr),
    .clr_dslot_o(clr_ds)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one-cycle request; returns at the negedge after the capturing edge
  task automatic fire(logic req, logic ret, logic [4:0] c, logic [31:0] p,
                      logic ds, logic [31:0] s);
    @(negedge clk);
    exc_req = req; rfe = ret; cause = c; pc = p; dslot = ds; sr = s;
    @(negedge clk);
    exc_req = 1'b0; rfe = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 epcr", epcr, 0);      chk("R1 esr", esr, 0);
    chk("R1 eear", eear, 0);      chk("R1 redir_pc", redir_pc, 0);
    chk("R1 pulses", {27'd0, redir_v, sr_we, halt, cerr, clr_ds}, 0);
    chk("R1 sr_wd", sr_wd, 0);    chk("R1 halt_pc", halt_pc, 0);
  endtask

  task automatic t_next_class;
    fire(1, 0, 5'hC, 32'h0000_1000, 0, 32'h0000_4001);
    chk("R2 syscall epcr", epcr, 32'h0000_1004);
    chk("R6 syscall redir_v", redir_v, 1);
    chk("R6 syscall vec eph", redir_pc, 32'hF000_0C00);
    chk("R5 esr", esr, 32'h0000_4001);
    chk("R5 sr_we", sr_we, 1);
    chk("R5 sr_wd dsx clear", sr_wd, 32'h0000_4001);
    chk("R10 clr on entry", clr_ds, 1);
    @(negedge clk);
    chk("R6 redir one cycle", redir_v, 0);
    chk("R10 clr one cycle", clr_ds, 0);
    fire(1, 0, 5'hD, 32'h0000_2000, 1, 32'h0000_0000);
    chk("R2 fpu dslot epcr", epcr, 32'h0000_2000);
    chk("R6 fpu vec", redir_pc, 32'h0000_0D00);
    chk("R5 sr_wd dsx set", sr_wd, 32'h0000_2000);
  endtask

  task automatic t_cur_class;
    fire(1, 0, 5'h2, 32'h0000_3000, 0, 32'h0);
    chk("R3 buserr epcr", epcr, 32'h0000_3000);
    chk("R6 buserr vec", redir_pc, 32'h0000_0200);
    fire(1, 0, 5'h6, 32'h0000_3100, 1, 32'h0);
    chk("R3 align dslot epcr", epcr, 32'h0000_30FC);
    fire(1, 0, 5'hB, 32'h0000_3200, 0, 32'h0);
    chk("R3 range epcr", epcr, 32'h0000_3200);
    chk("R8 eear untouched by range", eear, 0);
  endtask

  task automatic t_illegal;
    fire(1, 0, 5'h7, 32'h0000_5008, 1, 32'h0000_2000);
    chk("R3 illegal dslot epcr", epcr, 32'h0000_5004);
    chk("R8 eear", eear, 32'h0000_5008);
    fire(1, 0, 5'hC, 32'h0000_6000, 0, 32'h0);
    chk("R8 eear kept", eear, 32'h0000_5008);
  endtask

  task automatic t_reset_cause;
    // epcr holds 0x6004 from previous test
    fire(1, 0, 5'h1, 32'h0000_7000, 0, 32'h0000_4123);
    chk("R4 epcr kept", epcr, 32'h0000_6004);
    chk("R4 esr saved", esr, 32'h0000_4123);
    chk("R4 vec", redir_pc, 32'hF000_0100);
    chk("R4 redir_v", redir_v, 1);
  endtask

  task automatic t_trap;
    fire(1, 0, 5'hE, 32'h0000_8888, 1, 32'h0000_0055);
    chk("R7 halt", halt, 1);
    chk("R7 halt_pc", halt_pc, 32'h0000_8888);
    chk("R7 no redir", redir_v, 0);
    chk("R7 no sr_we", sr_we, 0);
    chk("R7 epcr kept", epcr, 32'h0000_6004);
    chk("R7 esr kept", esr, 32'h0000_4123);
    chk("R7 eear kept", eear, 32'h0000_5008);
    chk("R10 no clr on trap", clr_ds, 0);
    @(negedge clk);
    chk("R7 halt one cycle", halt, 0);
  endtask

  task automatic t_bad;
    fire(1, 0, 5'h1F, 32'h0000_9000, 0, 32'h0000_0077);
    chk("R11 err", cerr, 1);
    chk("R11 no redir", redir_v, 0);
    chk("R11 no halt", halt, 0);
    chk("R11 epcr kept", epcr, 32'h0000_6004);
    chk("R11 esr kept", esr, 32'h0000_4123);
    chk("R10 no clr on bad", clr_ds, 0);
    fire(1, 0, 5'h3, 32'h0000_9100, 0, 32'h0);
    chk("R11 err cause 3", cerr, 1);
  endtask

  task automatic t_rfe;
    fire(0, 1, 5'h0, 32'h0, 0, 32'h0);
    chk("R9 redir_v", redir_v, 1);
    chk("R9 redir_pc", redir_pc, 32'h0000_6004);
    chk("R9 sr_we", sr_we, 1);
    chk("R9 sr_wd", sr_wd, 32'h0000_C123);
    chk("R10 clr on rfe", clr_ds, 1);
  endtask

  task automatic t_collide;
    fire(1, 1, 5'hC, 32'h0000_A000, 0, 32'h0000_0000);
    chk("R12 epcr", epcr, 32'h0000_A004);
    chk("R12 redir to vector", redir_pc, 32'h0000_0C00);
    chk("R12 sr_wd entry", sr_wd, 32'h0000_0000);
  endtask

  task automatic t_idle;
    @(negedge clk);
    sr = 32'hFFFF_FFFF; pc = 32'h1234_5678; cause = 5'hC;
    repeat (4) @(negedge clk);
    chk("R13 epcr", epcr, 32'h0000_A004);
    chk("R13 esr", esr, 32'h0000_0000);
    chk("R13 eear", eear, 32'h0000_5008);
    chk("R13 pulses", {27'd0, redir_v, sr_we, halt, cerr, clr_ds}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_next_class();
    t_cur_class();
    t_illegal();
    t_reset_cause();
    t_trap();
    t_bad();
    t_rfe();
    t_collide();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule